// File: doc/BRIEF.md
# Two-Rank Transmit Word Stage

This block stages a 16-bit transmit word between a subsystem data bus and a serial encoder. The first rank either passes the bus straight through or keeps a captured copy. The second rank is the word the encoder shifts out. It takes the first-rank output once, on the clock edge where the send strobe is first seen high. It then ignores its inputs until the strobe has gone low and risen again. While one word is being shifted, the host can therefore prepare the next word in the first rank.

Every control is split by byte lane. This lets a host with an 8-bit bus place the same byte on both lanes and fill the word in two steps, opening one lane at a time. Bit 15 of the first-rank output is also driven out as a serial bit. This gives a direct serial path from the bus to the encoder when the upper lane is left open.

Top module: `tx_word_stage`

## Requirements
- R1: While rst_n is low, word_q is 0 and the stored first-rank value is cleared to 0. A load with both lanes closed right after reset therefore gives 0.
- R2: A lane whose rank-1 open control is high is transparent: a load in that cycle takes the bus value of that lane as it is in that cycle.
- R3: At each clock edge where a lane's open control is high, the lane stores the bus. While the control is low, the lane keeps the value from the last such edge, whatever the bus does.
- R4: A load happens at the clock edge where send_strobe is sampled high after being sampled low, or where it is high in the first cycle after reset. The loaded value is visible on word_q after that edge.
- R5: While send_strobe stays high after a load, word_q does not change, even when the bus or the first rank change.
- R6: At a load edge, word_q[7:0] is replaced only if rank2_load_lo is high, and word_q[15:8] only if rank2_load_hi is high. A lane whose load control is low keeps its old value.
- R7: The open controls of the two lanes act independently. With the same byte driven on both lanes, opening the lower lane and then the upper lane builds a 16-bit word from two bytes.
- R8: serial_bit equals bit 15 of the first-rank output at all times. It follows bus_d[15] combinationally while rank1_open_hi is high, and holds the stored bit otherwise.
- R9: A new word captured in the first rank while send_strobe is still high is loaded at the next rising edge of send_strobe, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| bus_d | input | 16 | Subsystem data bus |
| rank1_open_lo | input | 1 | Lower lane of rank 1: high transparent, low hold |
| rank1_open_hi | input | 1 | Upper lane of rank 1: high transparent, low hold |
| rank2_load_lo | input | 1 | Lower lane of rank 2 load enable |
| rank2_load_hi | input | 1 | Upper lane of rank 2 load enable |
| send_strobe | input | 1 | Send strobe; its rising edge loads rank 2 |
| word_q | output | 16 | Staged word for the encoder |
| serial_bit | output | 1 | Bit 15 of the rank-1 output |

## Verification
serial_bit is combinational, so it is checked one time step after the inputs change, inside the same cycle. word_q passes through one register: a load set up after a falling edge shows on word_q after the next rising edge. The bench drives every input just after a falling edge and compares word_q at the next falling edge. Its reference model updates its stored first-rank value and expected word on the same rising edges. This keeps each comparison exactly one edge behind its stimulus.

// File: rtl/tx_word_stage.sv
module tx_word_stage #(
  parameter int LANE_W = 8,
  localparam int WORD_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] bus_d,
  input  logic              rank1_open_lo,
  input  logic              rank1_open_hi,
  input  logic              rank2_load_lo,
  input  logic              rank2_load_hi,
  input  logic              send_strobe,
  output logic [WORD_W-1:0] word_q,
  output logic              serial_bit
);

  logic [1:0]        open_v;
  logic [1:0]        load_v;
  logic [WORD_W-1:0] r1_out;
  logic              send_d;
  logic              send_rise;

  assign open_v    = {rank1_open_hi, rank1_open_lo};
  assign load_v    = {rank2_load_hi, rank2_load_lo};
  assign send_rise = send_strobe & ~send_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) send_d <= 1'b0;
    else        send_d <= send_strobe;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam int LSB = g * LANE_W;
    logic [LANE_W-1:0] held;
    logic [LANE_W-1:0] stage;

    assign r1_out[LSB +: LANE_W] = open_v[g] ? bus_d[LSB +: LANE_W] : held;
    assign word_q[LSB +: LANE_W] = stage;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)         held <= '0;
      else if (open_v[g]) held <= bus_d[LSB +: LANE_W];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                     stage <= '0;
      else if (send_rise && load_v[g]) stage <= r1_out[LSB +: LANE_W];
  end

  assign serial_bit = r1_out[WORD_W-1];

endmodule

// File: rtl/tx_word_stage_chk.sv
module tx_word_stage_chk #(
  parameter int LANE_W = 8,
  localparam int WORD_W = 2 * LANE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] bus_d,
  input logic              rank1_open_lo,
  input logic              rank1_open_hi,
  input logic              rank2_load_lo,
  input logic              rank2_load_hi,
  input logic              send_strobe,
  input logic [WORD_W-1:0] word_q,
  input logic              serial_bit
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  always_comb
    if (!rst_n) assert_reset_clear_R1: assert (word_q == '0);

  assert_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    armed && send_strobe && $past(send_strobe) |=> $stable(word_q));

  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !send_strobe |=> $stable(word_q));

  assert_lane_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rank2_load_lo |=> $stable(word_q[LANE_W-1:0]));

  assert_lane_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rank2_load_hi |=> $stable(word_q[WORD_W-1:LANE_W]));

  assert_pass_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $rose(send_strobe) && rank2_load_lo && rank1_open_lo
    |=> word_q[LANE_W-1:0] == $past(bus_d[LANE_W-1:0]));

  assert_serial_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rank1_open_hi |-> serial_bit == bus_d[WORD_W-1]);

endmodule

bind tx_word_stage tx_word_stage_chk #(.LANE_W(LANE_W)) u_chk (.*);

// File: tb/tb_tx_word_stage.sv
`timescale 1ns/1ps
module tb_tx_word_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_d = '0;
  logic        open_lo = 0, open_hi = 0, load_lo = 0, load_hi = 0, send = 0;
  logic [15:0] word_q;
  logic        serial_bit;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_held, m_word;
  logic        m_prev;

  always #10 clk = ~clk;

  tx_word_stage dut (
    .clk(clk), .rst_n(rst_n), .bus_d(bus_d),
    .rank1_open_lo(open_lo), .rank1_open_hi(open_hi),
    .rank2_load_lo(load_lo), .rank2_load_hi(load_hi),
    .send_strobe(send), .word_q(word_q), .serial_bit(serial_bit)
  );

  function automatic logic [15:0] r1_view(logic [15:0] b, logic [15:0] h, logic olo, logic ohi);
    return {ohi ? b[15:8] : h[15:8], olo ? b[7:0] : h[7:0]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_held <= '0; m_word <= '0; m_prev <= 1'b0;
    end else begin
      logic [15:0] v;
      v = r1_view(bus_d, m_held, open_lo, open_hi);
      if (send && !m_prev) begin
        if (load_lo) m_word[7:0]  <= v[7:0];
        if (load_hi) m_word[15:8] <= v[15:8];
      end
      if (open_lo) m_held[7:0]  <= bus_d[7:0];
      if (open_hi) m_held[15:8] <= bus_d[15:8];
      m_prev <= send;
    end
  end

  task automatic chk(logic [15:0] act, logic [15:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [15:0] b, logic olo, logic ohi, logic llo, logic lhi, logic s);
    bus_d = b; open_lo = olo; open_hi = ohi; load_lo = llo; load_hi = lhi; send = s;
    #1;
    chk({15'd0, serial_bit}, {15'd0, r1_view(bus_d, m_held, open_lo, open_hi) >> 15}, "R8");
  endtask

  task automatic tick(string tag);
    @(posedge clk); @(negedge clk);
    chk(word_q, m_word, tag);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(word_q, 16'h0000, "R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    drive(16'hFFFF, 0, 0, 1, 1, 1); tick("R1");
    chk(word_q, 16'h0000, "R1 cleared first rank");

    drive(16'h1234, 1, 1, 1, 1, 0); tick("R2");
    drive(16'h1234, 1, 1, 1, 1, 1); tick("R2");
    chk(word_q, 16'h1234, "R2 transparent load");

    drive(16'hABCD, 1, 1, 0, 0, 0); tick("R3");
    drive(16'hFFFF, 0, 0, 0, 0, 0); tick("R3");
    drive(16'h0F0F, 0, 0, 1, 1, 1); tick("R3");
    chk(word_q, 16'hABCD, "R3 held value loaded");

    drive(16'h5A5A, 1, 1, 1, 1, 1); tick("R5");
    drive(16'h9999, 0, 0, 1, 1, 1); tick("R5");
    chk(word_q, 16'hABCD, "R5 locked while strobe high");

    drive(16'h0000, 0, 0, 1, 1, 0); tick("R9");
    chk(word_q, 16'hABCD, "R9 no load on fall");
    drive(16'h0000, 0, 0, 1, 1, 1); tick("R9");
    chk(word_q, 16'h5A5A, "R9 next word on next rise");

    drive(16'h1111, 1, 1, 1, 0, 0); tick("R6");
    drive(16'h1111, 1, 1, 1, 0, 1); tick("R6");
    chk(word_q, 16'h5A11, "R6 lower lane only");
    drive(16'h2222, 1, 1, 0, 1, 0); tick("R6");
    drive(16'h2222, 1, 1, 0, 1, 1); tick("R6");
    chk(word_q, 16'h2211, "R6 upper lane only");

    drive(16'hC3C3, 1, 0, 0, 0, 0); tick("R7");
    drive(16'h7E7E, 0, 1, 0, 0, 0); tick("R7");
    drive(16'h0000, 0, 0, 1, 1, 1); tick("R7");
    chk(word_q, 16'h7EC3, "R7 byte fill");

    drive(16'h8000, 0, 1, 0, 0, 0);
    chk({15'd0, serial_bit}, 16'h0001, "R8 follows bus high");
    drive(16'h0000, 0, 1, 0, 0, 0);
    chk({15'd0, serial_bit}, 16'h0000, "R8 follows bus low");
    tick("R8");
    drive(16'hFFFF, 0, 0, 0, 0, 0);
    chk({15'd0, serial_bit}, 16'h0000, "R8 held bit");
    tick("R8");

    void'($urandom(32'd2024));
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] b;
      b = $urandom();
      if (($urandom() % 4) == 0) b = {b[7:0], b[7:0]};
      drive(b, $urandom() % 2, $urandom() % 2, ($urandom() % 4) != 0,
            ($urandom() % 4) != 0, ($urandom() % 3) == 0);
      tick("R4 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule